// File: doc/BRIEF.md
# SHA-256 Message Schedule Generator

This block produces the expanded message words for one 512-bit SHA-256 block. It feeds an iterative compression engine that consumes one word per clock cycle. The sixteen most recent schedule words are kept in a window of separate 32-bit registers. Every advance drops the oldest word and appends a newly computed one, so the full 64-word expansion is never stored.

The round logic pulses `init_i` to capture a new block. It then pulses `next_i` once per round to step to the following word. `w_o` always presents the word for the current round straight from a register. A full block therefore needs one load cycle and 63 advance cycles, which fits within a 66-cycle per-block budget.

Top module: `msg_schedule_w`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a rising edge), `w_o` is 0, the round index is 0 and every window register is 0. An advance issued before any load therefore keeps producing 0.
- R2: A rising edge with `init_i` high loads the block. From the next cycle, `w_o` equals `block_i[511:480]`.
- R3: For rounds 1 to 15, the word shown after the t-th advance is `block_i[511-32t -: 32]`. Words come from the loaded block, most significant word first.
- R4: For rounds 16 to 63, the word shown is W[t] = s1(W[t-2]) + W[t-7] + s0(W[t-15]) + W[t-16], modulo 2^32.
- R5: s0(x) = ROTR7(x) ^ ROTR18(x) ^ SHR3(x), and s1(x) = ROTR17(x) ^ ROTR19(x) ^ SHR10(x). For the padded three-byte message "abc", W16 = 0x61626380 and W17 = 0x000F0000.
- R6: Each rising edge with `next_i` high advances the schedule by exactly one word. With neither strobe high, `w_o` holds its value.
- R7: `init_i` takes priority over `next_i` in the same cycle. A load in mid-schedule restarts at round 0 with the new block.
- R8: Once round 63 is shown, further `next_i` pulses are ignored, and `w_o` keeps W63 until the next load.
- R9: A reset in mid-schedule clears the window, so `w_o` reads 0 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| init_i | input | 1 | Load strobe: capture `block_i` and restart at round 0 |
| next_i | input | 1 | Advance strobe: step to the next schedule word |
| block_i | input | 512 | Message block, word 0 in the top 32 bits |
| w_o | output | 32 | Schedule word for the current round |

## Verification
The expansion is exercised with four kinds of block:
- an all-zero block, where any stray term would show as a non-zero word;
- an all-ones block, which stresses carries and the shift terms of both sigma functions;
- the padded "abc" block, whose known W16 and W17 separate the rotate amounts from the shift amounts;
- a set of random blocks, some stepped with idle cycles between advances, so a word that moves without a strobe is seen.

Directed cases cover the remaining behaviour: a load colliding with an advance, a reload in mid-schedule, advances past round 63, and a reset in mid-run. These show priority, restart and saturation separately from the arithmetic.

// File: rtl/sha256_sched_pkg.sv
// Shared constants, word type and the two small sigma functions of the
// SHA-256 message expansion. Assumes 32-bit words as the algorithm fixes.
package sha256_sched_pkg;

    localparam int WORD_W     = 32;
    localparam int WIN_LEN    = 16;
    localparam int NUM_ROUNDS = 64;

    typedef logic [WORD_W-1:0] word_t;

    // Rotate right by a constant amount.
    function automatic word_t rotr(input word_t x, input int n);
        return (x >> n) | (x << (WORD_W - n));
    endfunction

    // Small sigma 0: rotate 7, rotate 18, shift 3.
    function automatic word_t ssig0(input word_t x);
        return rotr(x, 7) ^ rotr(x, 18) ^ (x >> 3);
    endfunction

    // Small sigma 1: rotate 17, rotate 19, shift 10.
    function automatic word_t ssig1(input word_t x);
        return rotr(x, 17) ^ rotr(x, 19) ^ (x >> 10);
    endfunction

endpackage

// File: rtl/ws_round_ctr.sv
// Round index of the schedule. Restarts on load, steps on advance and
// saturates at the final round. Assumes load has priority over advance.
module ws_round_ctr #(
    parameter int NUM_ROUNDS = sha256_sched_pkg::NUM_ROUNDS
) (
    input  logic clk,
    input  logic rst_n,
    input  logic init_i,
    input  logic next_i,
    output logic adv_o,
    output logic at_last_o
);
    localparam int CNT_W = $clog2(NUM_ROUNDS);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(NUM_ROUNDS - 1);

    logic [CNT_W-1:0] cnt;

    assign at_last_o = (cnt == LAST);
    assign adv_o     = next_i & ~init_i & ~at_last_o;

    // Round index update: reset/load clears, advance increments.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (init_i) begin
            cnt <= '0;
        end else if (adv_o) begin
            cnt <= cnt + 1'b1;
        end
    end

    // R7: a load always restarts the round index
    assert_load_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
        init_i |=> (cnt == '0));

    // R6: an accepted advance moves the index by exactly one
    assert_step_one_R6: assert property (@(posedge clk) disable iff (!rst_n)
        adv_o |=> (cnt == $past(cnt) + 1'b1));

    // R8: the final round is sticky under advance strobes
    assert_last_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (at_last_o && next_i && !init_i) |=> at_last_o);

endmodule

// File: rtl/ws_expand.sv
// Combinational computation of the next schedule word from four window
// taps. Assumes taps are W[t-2], W[t-7], W[t-15], W[t-16] of the new word.
module ws_expand
    import sha256_sched_pkg::*;
(
    input  word_t near_i,
    input  word_t mid_i,
    input  word_t far_i,
    input  word_t oldest_i,
    output word_t fresh_o
);
    // New word: sum modulo 2^32 of the four terms.
    always_comb begin
        fresh_o = ssig1(near_i) + mid_i + ssig0(far_i) + oldest_i;
    end

endmodule

// File: rtl/ws_window.sv
// Sliding window of WIN_LEN separate word registers. Slot 0 holds the
// current word. A load fills all slots from the block (top word into slot 0);
// a shift moves every slot down one place and writes the fresh word to the end.
module ws_window
    import sha256_sched_pkg::*;
#(
    parameter int WIN_LEN = sha256_sched_pkg::WIN_LEN
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      load_i,
    input  logic                      shift_i,
    input  logic [WIN_LEN*WORD_W-1:0] blk_i,
    input  word_t                     fresh_i,
    output word_t                     head_o,
    output word_t                     far_o,
    output word_t                     mid_o,
    output word_t                     near_o
);
    localparam int TAIL     = WIN_LEN - 1;
    localparam int NEAR_IDX = WIN_LEN - 2;
    localparam int MID_IDX  = WIN_LEN - 7;
    localparam int FAR_IDX  = 1;

    word_t slot [WIN_LEN];

    for (genvar i = 0; i < WIN_LEN; i++) begin : g_slot
        word_t shift_src;
        if (i == TAIL) begin : g_tail
            assign shift_src = fresh_i;
        end else begin : g_body
            assign shift_src = slot[i+1];
        end

        // Slot register: clear, load from block, or take the shifted-in word.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot[i] <= '0;
            end else if (load_i) begin
                slot[i] <= blk_i[(WIN_LEN-i)*WORD_W-1 -: WORD_W];
            end else if (shift_i) begin
                slot[i] <= shift_src;
            end
        end
    end

    assign head_o = slot[0];
    assign far_o  = slot[FAR_IDX];
    assign mid_o  = slot[MID_IDX];
    assign near_o = slot[NEAR_IDX];

    // R2: after a load the head shows the top word of the block
    assert_load_head_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (head_o == $past(blk_i[WIN_LEN*WORD_W-1 -: WORD_W])));

    // R6: a shift brings the following word to the head
    assert_shift_head_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_i && !load_i) |=> (head_o == $past(far_o)));

    // R6: without load or shift the window does not move
    assert_quiet_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift_i && !load_i) |=> ($stable(head_o) && $stable(near_o)));

endmodule

// File: rtl/msg_schedule_w.sv
// SHA-256 message schedule generator. Presents one expanded word per round
// from a 16-register sliding window. Assumes the caller pulses init_i once
// per block and next_i once per consumed word.
module msg_schedule_w
    import sha256_sched_pkg::*;
#(
    parameter int WIN_LEN    = sha256_sched_pkg::WIN_LEN,
    parameter int NUM_ROUNDS = sha256_sched_pkg::NUM_ROUNDS
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      init_i,
    input  logic                      next_i,
    input  logic [WIN_LEN*WORD_W-1:0] block_i,
    output logic [WORD_W-1:0]         w_o
);
    logic  adv;
    logic  at_last;
    word_t head_w;
    word_t far_w;
    word_t mid_w;
    word_t near_w;
    word_t fresh_w;

    ws_round_ctr #(.NUM_ROUNDS(NUM_ROUNDS)) i_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .init_i    (init_i),
        .next_i    (next_i),
        .adv_o     (adv),
        .at_last_o (at_last)
    );

    ws_window #(.WIN_LEN(WIN_LEN)) i_win (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (init_i),
        .shift_i (adv),
        .blk_i   (block_i),
        .fresh_i (fresh_w),
        .head_o  (head_w),
        .far_o   (far_w),
        .mid_o   (mid_w),
        .near_o  (near_w)
    );

    ws_expand i_exp (
        .near_i   (near_w),
        .mid_i    (mid_w),
        .far_i    (far_w),
        .oldest_i (head_w),
        .fresh_o  (fresh_w)
    );

    assign w_o = head_w;

    // R8: advances at the final round leave the output unchanged
    assert_saturate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (at_last && next_i && !init_i) |=> $stable(w_o));

    // R7: load wins over a simultaneous advance
    assert_init_priority_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (init_i && next_i) |=> (w_o == $past(block_i[WIN_LEN*WORD_W-1 -: WORD_W])));

endmodule

// File: tb/test_msg_schedule_w.sv
module test_msg_schedule_w;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         init_s;
    logic         next_s;
    logic [511:0] blk_s;
    logic [31:0]  w_o;

    int total = 0;
    int bad   = 0;
    logic [31:0] exp_w [64];

    localparam logic [511:0] ABC_BLK = {32'h61626380, 448'h0, 32'h00000018};

    always #4 clk = ~clk;

    msg_schedule_w i_msg_schedule_w (
        .clk     (clk),
        .rst_n   (rst_n),
        .init_i  (init_s),
        .next_i  (next_s),
        .block_i (blk_s),
        .w_o     (w_o)
    );

    function automatic logic [31:0] rr(input logic [31:0] x, input int n);
        return (x >> n) | (x << (32 - n));
    endfunction

    function automatic logic [31:0] m_s0(input logic [31:0] x);
        return rr(x, 7) ^ rr(x, 18) ^ (x >> 3);
    endfunction

    function automatic logic [31:0] m_s1(input logic [31:0] x);
        return rr(x, 17) ^ rr(x, 19) ^ (x >> 10);
    endfunction

    task automatic model(input logic [511:0] b);
        for (int t = 0; t < 64; t++) begin
            if (t < 16) exp_w[t] = b[511-32*t -: 32];
            else exp_w[t] = m_s1(exp_w[t-2]) + exp_w[t-7] + m_s0(exp_w[t-15]) + exp_w[t-16];
        end
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_init(input logic [511:0] b);
        blk_s  = b;
        init_s = 1'b1;
        @(negedge clk);
        init_s = 1'b0;
    endtask

    task automatic do_next();
        next_s = 1'b1;
        @(negedge clk);
        next_s = 1'b0;
    endtask

    task automatic run_block(input logic [511:0] b, input bit stalls);
        logic [31:0] held;
        model(b);
        do_init(b);
        check("R2", w_o, exp_w[0]);
        for (int t = 1; t < 64; t++) begin
            if (stalls && ($urandom % 4 == 0)) begin
                held = w_o;
                @(negedge clk);
                check("R6", w_o, held);
            end
            do_next();
            check(t < 16 ? "R3" : "R4", w_o, exp_w[t]);
        end
        do_next();
        check("R8", w_o, exp_w[63]);
        do_next();
        check("R8", w_o, exp_w[63]);
    endtask

    function automatic logic [511:0] rand_blk();
        logic [511:0] r;
        for (int k = 0; k < 16; k++) r[32*k +: 32] = $urandom;
        return r;
    endfunction

    initial begin
        logic [511:0] b2;
        void'($urandom(32'd20240611));
        rst_n  = 1'b0;
        init_s = 1'b0;
        next_s = 1'b0;
        blk_s  = '0;
        repeat (3) @(negedge clk);
        check("R1", w_o, 32'h0);
        rst_n = 1'b1;
        do_next();
        check("R1", w_o, 32'h0);

        run_block('0, 1'b0);
        run_block({512{1'b1}}, 1'b0);
        run_block(ABC_BLK, 1'b0);

        // R5 directed: known words of the "abc" block
        do_init(ABC_BLK);
        for (int t = 0; t < 16; t++) do_next();
        check("R5", w_o, 32'h61626380);
        do_next();
        check("R5", w_o, 32'h000F0000);

        // R7: reload mid-schedule with simultaneous advance
        b2 = rand_blk();
        model(b2);
        blk_s  = b2;
        init_s = 1'b1;
        next_s = 1'b1;
        @(negedge clk);
        init_s = 1'b0;
        next_s = 1'b0;
        check("R7", w_o, exp_w[0]);
        do_next();
        check("R7", w_o, exp_w[1]);
        for (int t = 2; t < 20; t++) do_next();
        check("R7", w_o, exp_w[19]);

        // R9: reset in mid-run clears the window
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R9", w_o, 32'h0);
        for (int t = 0; t < 20; t++) do_next();
        check("R9", w_o, 32'h0);

        for (int n = 0; n < 12; n++) run_block(rand_blk(), n[0]);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog (all requirements): got hang expected completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule